// File: doc/BRIEF.md
# Serial Command Port for an Eight-Way Low-Side Switch Bank

This block is the digital serial slave of a switch controller that drives eight load channels. A host selects it by pulling an active-low select line, clocks one command bit per channel into an 8-bit register, and reads the channels' status bits back on the serial output in the same transfer. When the select line rises, the command frame is moved into an output latch that drives the eight channel-enable lines. The move happens only if the frame held a whole number of bytes. When the select line falls, the current channel status is captured into the same register so that it can be shifted out.

The serial pins are oversampled by a fast system clock. Each one passes through a synchronizer, and all serial events are acted on from edges found in the synchronized copies. Frames longer than eight bits pass the earlier bits through the register and out of the serial output unchanged. Several ports can therefore be chained, with one select line shared by all of them.

Top module: `octal_switch_spi_port`

## Requirements
- R1: While `rst_n` is low or `uv_flag` is high, every `chan_on` bit is 0 (all channels off). The port comes back from this state with all channels off and accepts the next frame normally.
- R2: Command bits are taken on falling edges of `ser_clk` while `sel_n` is low, most significant first. In an 8-bit frame the first bit sent controls channel 7 (`chan_on[7]`) and the last bit controls channel 0.
- R3: A command bit of 1 switches its channel off (`chan_on` bit 0), and a 0 switches it on (`chan_on` bit 1). `chan_on` changes only in response to a rising edge of `sel_n`, and never while `sel_n` is still low.
- R4: At the rising edge of `sel_n`, the frame is latched only when the number of `ser_clk` falling edges since `sel_n` fell is 8, 16, 24 and so on. After 0 clocks or any count that is not a multiple of 8, `chan_on` keeps its previous value.
- R5: At the falling edge of `sel_n`, `chan_status` is captured. `ser_dout` presents `chan_status[7]` first, then `chan_status[6]` down to `chan_status[0]`, moving to the next bit only on rising edges of `ser_clk`.
- R6: `ser_dout_en` is 1 exactly while `sel_n` is low, and this holds even during reset.
- R7: While `sel_n` is high, activity on `ser_clk` and `ser_din` changes neither `chan_on` nor `ser_dout`.
- R8: In a frame of more than 8 clocks, after the eight status bits `ser_dout` carries the command bits in the order they were sent. The last eight bits sent are the ones that get latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | External reset, active low |
| uv_flag | input | 1 | Supply undervoltage indication, active high, acts as reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial command data from the host |
| sel_n | input | 1 | Port select, active low |
| chan_status | input | FRAME_W | Per-channel status bits, bit 7 sent first |
| ser_dout | output | 1 | Serial status and pass-through data |
| ser_dout_en | output | 1 | Output driver enable for `ser_dout` |
| chan_on | output | FRAME_W | Channel enables, 1 means the channel is on |

## Verification
Every serial event lands three system clocks after its pin changes: two synchronizer stages plus the edge-detect cycle. A command bit enters the register three cycles after the `ser_clk` fall, `ser_dout` moves three cycles after a `ser_clk` rise or a `sel_n` fall, and `chan_on` updates three cycles after `sel_n` rises. Reset clears `chan_on` asynchronously, and `ser_dout_en` follows `sel_n` with no delay. The bench holds every serial pin for four system clocks per phase, reads `ser_dout` at the end of the high phase just before it drops `ser_clk`, and checks `chan_on` five cycles after the rise of `sel_n` and again just before it. All values are read on the falling edge of `clk`.

// File: rtl/osw_pkg.sv
package osw_pkg;

   localparam int unsigned OSW_DEF_CHANNELS    = 8;
   localparam int unsigned OSW_DEF_SYNC_STAGES = 2;

   function automatic bit osw_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/osw_sync.sv
module osw_sync #(
   parameter int unsigned W               = 1,
   parameter int unsigned STAGES          = 2,
   parameter logic [W-1:0] RST_VAL        = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/osw_edge.sv
module osw_edge #(
   parameter int unsigned W        = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);

   logic [W-1:0] prev;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) prev <= RST_VAL;
      else     prev <= lvl;
   end

   generate
      for (genvar b = 0; b < int'(W); b++) begin : g_bit
         assign rise[b] = lvl[b] & ~prev[b];
         assign fall[b] = prev[b] & ~lvl[b];
      end
   endgenerate

endmodule

// File: rtl/osw_shifter.sv
module osw_shifter #(
   parameter int unsigned FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_val,
   input  logic               shift_en,
   input  logic               shift_in,
   input  logic               out_en,
   output logic [FRAME_W-1:0] shreg,
   output logic               dout
);

   localparam int unsigned MSB = FRAME_W - 1;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         shreg <= '0;
         dout  <= 1'b0;
      end else if (load) begin
         shreg <= load_val;
         dout  <= load_val[MSB];
      end else begin
         if (shift_en) shreg <= {shreg[MSB-1:0], shift_in};
         if (out_en)   dout  <= shreg[MSB];
      end
   end

endmodule

// File: rtl/osw_cmd_latch.sv
module osw_cmd_latch #(
   parameter int unsigned FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               clear,
   input  logic               tick,
   input  logic               commit,
   input  logic [FRAME_W-1:0] cmd,
   output logic               cnt_zero,
   output logic               any_clk,
   output logic [FRAME_W-1:0] latch_q
);

   localparam int unsigned CNT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;

   logic [CNT_W-1:0] cnt;

   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt     <= '0;
         any_clk <= 1'b0;
      end else if (clear || commit) begin
         cnt     <= '0;
         any_clk <= 1'b0;
      end else if (tick) begin
         cnt     <= cnt + 1'b1;
         any_clk <= 1'b1;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)                             latch_q <= '1;
      else if (commit && any_clk && cnt_zero) latch_q <= cmd;
   end

endmodule

// File: rtl/octal_switch_spi_port.sv
module octal_switch_spi_port #(
   parameter int unsigned FRAME_W     = osw_pkg::OSW_DEF_CHANNELS,
   parameter int unsigned SYNC_STAGES = osw_pkg::OSW_DEF_SYNC_STAGES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               uv_flag,
   input  logic               ser_clk,
   input  logic               ser_din,
   input  logic               sel_n,
   input  logic [FRAME_W-1:0] chan_status,
   output logic               ser_dout,
   output logic               ser_dout_en,
   output logic [FRAME_W-1:0] chan_on
);

   generate
      if (!osw_pkg::osw_is_pow2(FRAME_W) || FRAME_W < 4) begin : g_bad_width
         $error("FRAME_W must be a power of two of at least 4");
      end
      if (SYNC_STAGES > 6) begin : g_bad_sync
         $error("SYNC_STAGES above 6 is not supported");
      end
   endgenerate

   logic               rst_int;
   logic [1:0]         ctl_s;
   logic [1:0]         ctl_rise;
   logic [1:0]         ctl_fall;
   logic               din_s;
   logic               sel_s;
   logic               sclk_fall_a;
   logic               sclk_rise_a;
   logic               sel_fall;
   logic               sel_rise;
   logic [FRAME_W-1:0] shreg;
   logic               dout_q;
   logic               cnt_zero;
   logic               any_clk;
   logic [FRAME_W-1:0] latch_q;

   assign rst_int = ~rst_n | uv_flag;

   osw_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync_ctl (
      .clk (clk), .rst (rst_int), .d ({ser_clk, sel_n}), .q (ctl_s)
   );

   osw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
      .clk (clk), .rst (rst_int), .d (ser_din), .q (din_s)
   );

   osw_edge #(.W(2), .RST_VAL(2'b01)) u_edge (
      .clk (clk), .rst (rst_int), .lvl (ctl_s), .rise (ctl_rise), .fall (ctl_fall)
   );

   assign sel_s       = ctl_s[0];
   assign sel_fall    = ctl_fall[0];
   assign sel_rise    = ctl_rise[0];
   assign sclk_fall_a = ctl_fall[1] & ~sel_s;
   assign sclk_rise_a = ctl_rise[1] & ~sel_s;

   osw_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk      (clk),
      .rst      (rst_int),
      .load     (sel_fall),
      .load_val (chan_status),
      .shift_en (sclk_fall_a),
      .shift_in (din_s),
      .out_en   (sclk_rise_a),
      .shreg    (shreg),
      .dout     (dout_q)
   );

   osw_cmd_latch #(.FRAME_W(FRAME_W)) u_latch (
      .clk      (clk),
      .rst      (rst_int),
      .clear    (sel_fall),
      .tick     (sclk_fall_a),
      .commit   (sel_rise),
      .cmd      (shreg),
      .cnt_zero (cnt_zero),
      .any_clk  (any_clk),
      .latch_q  (latch_q)
   );

   generate
      for (genvar c = 0; c < int'(FRAME_W); c++) begin : g_chan
         assign chan_on[c] = ~latch_q[c];
      end
   endgenerate

   assign ser_dout    = dout_q;
   assign ser_dout_en = ~sel_n;

endmodule

// File: rtl/osw_checker.sv
module osw_checker #(
   parameter int unsigned FRAME_W = 8
) (
   input logic               clk,
   input logic               rst_int,
   input logic [FRAME_W-1:0] chan_on,
   input logic               ser_dout,
   input logic               sel_s,
   input logic               sel_rise,
   input logic               sel_fall,
   input logic               sclk_rise_a,
   input logic               cnt_zero,
   input logic               any_clk,
   input logic [FRAME_W-1:0] shreg
);

   always @(posedge clk) begin
      if (rst_int) AST_RESET_ALL_OFF: assert (chan_on == '0); // R1
   end

   AST_LATCH_AT_SEL_RISE: assert property (@(posedge clk) disable iff (rst_int)
      !$stable(chan_on) |-> $past(sel_rise)); // R3

   AST_LATCH_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (rst_int)
      !$stable(chan_on) |-> $past(cnt_zero && any_clk)); // R4

   AST_DOUT_MOVES_ON_EDGES: assert property (@(posedge clk) disable iff (rst_int)
      !$stable(ser_dout) |-> $past(sclk_rise_a || sel_fall)); // R5

   AST_IDLE_REG_FROZEN: assert property (@(posedge clk) disable iff (rst_int)
      (sel_s && $past(sel_s)) |-> $stable(shreg)); // R7

endmodule

bind octal_switch_spi_port osw_checker #(.FRAME_W(FRAME_W)) u_chk (
   .clk         (clk),
   .rst_int     (rst_int),
   .chan_on     (chan_on),
   .ser_dout    (ser_dout),
   .sel_s       (sel_s),
   .sel_rise    (sel_rise),
   .sel_fall    (sel_fall),
   .sclk_rise_a (sclk_rise_a),
   .cnt_zero    (cnt_zero),
   .any_clk     (any_clk),
   .shreg       (shreg)
);

// File: tb/tb_octal_switch_spi_port.sv
`timescale 1ns/1ps
module tb_octal_switch_spi_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       uv_flag = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_din = 1'b0;
   logic       sel_n = 1'b1;
   logic [7:0] chan_status = 8'h00;
   logic       ser_dout;
   logic       ser_dout_en;
   logic [7:0] chan_on;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] exp_off = 8'hFF;

   always #4 clk = ~clk;

   octal_switch_spi_port dut (
      .clk (clk), .rst_n (rst_n), .uv_flag (uv_flag), .ser_clk (ser_clk),
      .ser_din (ser_din), .sel_n (sel_n), .chan_status (chan_status),
      .ser_dout (ser_dout), .ser_dout_en (ser_dout_en), .chan_on (chan_on)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [63:0] exp_stream(input int n, input logic [63:0] bits,
                                              input logic [7:0] st);
      logic [63:0] r = '0;
      for (int i = 0; i < n; i++)
         r[n-1-i] = (i < 8) ? st[7-i] : bits[n-1-(i-8)];
      return r;
   endfunction

   function automatic logic [63:0] mask_n(input int n);
      return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
   endfunction

   task automatic frame(input int n, input logic [63:0] bits, input logic [7:0] st);
      logic [63:0] got = '0;
      chan_status = st;
      idle(2);
      sel_n = 1'b0;
      idle(4);
      chk("R6 enable while selected", {63'd0, ser_dout_en}, 64'd1);
      for (int i = 0; i < n; i++) begin
         ser_din = bits[n-1-i];
         idle(1);
         ser_clk = 1'b1;
         idle(4);
         got[n-1-i] = ser_dout;
         ser_clk = 1'b0;
         idle(4);
      end
      chk("R3 no change before select rise", {56'd0, chan_on}, {56'd0, ~exp_off});
      if (n > 0) chk("R5/R8 serial out stream", got & mask_n(n), exp_stream(n, bits, st));
      sel_n = 1'b1;
      if (n > 0 && (n % 8) == 0) exp_off = bits[7:0];
      idle(5);
      chk("R2/R3/R4 channel outputs", {56'd0, chan_on}, {56'd0, ~exp_off});
      chk("R6 enable off when deselected", {63'd0, ser_dout_en}, 64'd0);
   endtask

   initial begin
      logic [63:0] rb;
      int          n;
      logic        so_before;
      void'($urandom(32'd20240611));
      idle(3);
      chk("R1 reset all off", {56'd0, chan_on}, 64'd0);
      chk("R6 enable off at reset with select high", {63'd0, ser_dout_en}, 64'd0);
      rst_n = 1'b1;
      idle(4);
      chk("R1 idle after reset", {56'd0, chan_on}, 64'd0);

      // R2: first bit is channel 7
      frame(8, 64'h7F, 8'hA5);
      chk("R2 only channel 7 on", {56'd0, chan_on}, 64'h80);
      frame(8, 64'h53, 8'h3C);
      // R4: non-multiples and zero hold the latch
      frame(7, 64'h00, 8'h81);
      frame(9, 64'h1FF, 8'h5A);
      frame(0, 64'h0, 8'hFF);
      // R8: chained frames
      frame(16, 64'hC3E1, 8'h96);
      frame(24, 64'h12_34F0, 8'h0F);

      // R7: activity while deselected
      so_before = ser_dout;
      for (int i = 0; i < 5; i++) begin
         ser_din = ~ser_din; ser_clk = 1'b1; idle(4); ser_clk = 1'b0; idle(4);
      end
      chk("R7 outputs held while deselected", {55'd0, ser_dout, chan_on},
          {55'd0, so_before, ~exp_off});
      frame(8, 64'hF0, 8'h11);

      // R1: undervoltage acts as reset
      uv_flag = 1'b1;
      idle(2);
      chk("R1 undervoltage forces off", {56'd0, chan_on}, 64'd0);
      uv_flag = 1'b0;
      exp_off = 8'hFF;
      idle(4);
      frame(8, 64'h0F, 8'h22);

      // R1/R6: reset in the middle of a frame, select low
      sel_n = 1'b0;
      idle(4);
      ser_din = 1'b0; ser_clk = 1'b1; idle(4); ser_clk = 1'b0; idle(4);
      rst_n = 1'b0;
      idle(1);
      chk("R1 reset mid frame all off", {56'd0, chan_on}, 64'd0);
      chk("R6 enable during reset", {63'd0, ser_dout_en}, 64'd1);
      sel_n = 1'b1;
      idle(2);
      rst_n = 1'b1;
      exp_off = 8'hFF;
      idle(4);
      frame(8, 64'h3C, 8'h77);

      // random frames
      for (int k = 0; k < 40; k++) begin
         case ($urandom % 7)
            0: n = 0;  1: n = 3;  2: n = 7;  3: n = 9;
            4: n = 16; 5: n = 24; default: n = 8;
         endcase
         rb = {$urandom, $urandom};
         frame(n, rb, 8'($urandom));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule